// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Select

This block holds the 6-bit position of a digitally controlled resistor wiper. It drives a 64-bit one-hot enable that closes exactly one tap switch along a 63-segment resistor string. Position 0 selects the tap at the low end of the string. Position 63 selects the tap at the high end.

The position can change in four ways:
- A direct write from the host.
- A copy of one of several stored data registers.
- A single step up or down.
- A recall of stored register 0, which the surrounding logic requests once after power-up.

Each request is registered and then delayed by a fixed, parameterised number of clock edges, which models the bounded wiper response time. Only after that delay does the new position reach the tap enables. The position register is volatile and starts from a fixed reset value. The value that sets the wiper after power-up is the recall request. No write-protect input exists, so writes to the wiper cannot be blocked.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: At every cycle out of reset, `tapEn` has exactly one bit set, and that bit's index equals `position`. `tapEn` changes in the same cycle as `position`.
- R2: Position 0 enables `tapEn[0]`, the low end of the string. Position 63 enables `tapEn[63]`, the high end.
- R3: A direct write (`wrValid`) loads `wrData` into the position.
- R4: A transfer (`xferValid`) loads the stored register selected by `xferSel`. Register i occupies bits [6*i+5 : 6*i] of `dataRegs`.
- R5: A step request (`stepValid`) moves the position by one. `stepUp`=1 moves it toward the high end and `stepUp`=0 toward the low end. Steps requested on consecutive cycles each take effect.
- R6: Stepping up at 63 leaves 63. Stepping down at 0 leaves 0. Neither wraps.
- R7: A recall (`recallValid`) loads `recallData`. When a recall arrives in the same cycle as any host request, the recall wins.
- R8: Among host requests in the same cycle, write beats transfer, and transfer beats step.
- R9: A request sampled at a rising edge shows on `position` exactly `RESP_DLY` rising edges later, counting the sampling edge. Before then the old value holds. With no request in flight, the position does not change.
- R10: While `rstN` is low, `position` is `RESET_POS` (0 by default) and `tapEn` has only the matching bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| recallValid | input | 1 | Power-up recall request |
| recallData | input | 6 | Stored register 0 value used by the recall |
| wrValid | input | 1 | Direct write request |
| wrData | input | 6 | Direct write value |
| xferValid | input | 1 | Transfer request from a stored register |
| xferSel | input | 2 | Index of the stored register to copy |
| dataRegs | input | 24 | Stored register contents, register i at bits 6*i upward |
| stepValid | input | 1 | Single-step request |
| stepUp | input | 1 | Step direction, 1 = toward high end |
| position | output | 6 | Current wiper position |
| tapEn | output | 64 | One-hot tap switch enables |

## Verification
The properties watch the command that leaves the delay pipeline, and they assume the stimulus follows the encodings in R4. They assume nothing about how often requests arrive, so back-to-back and overlapping requests are legal. The bench changes inputs only on falling edges and holds each request for a single cycle. Each rising edge therefore samples a stable, well-defined request. The bench then checks the position one edge before the expected update and again on the update edge.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int unsigned POS_W = 6;

  typedef struct packed {
    logic             load;
    logic             stepEn;
    logic             stepUp;
    logic [POS_W-1:0] value;
  } wiperCmd_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned NUM_DR   = 4,
  parameter int unsigned RESP_DLY = 3,
  localparam int unsigned SEL_W   = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    recallValid,
  input  logic [POS_W-1:0]        recallData,
  input  logic                    wrValid,
  input  logic [POS_W-1:0]        wrData,
  input  logic                    xferValid,
  input  logic [SEL_W-1:0]        xferSel,
  input  logic [NUM_DR*POS_W-1:0] dataRegs,
  input  logic                    stepValid,
  input  logic                    stepUp,
  output wiperCmd_t               cmdOut
);
  wiperCmd_t        reqCmd;
  logic [POS_W-1:0] xferValue;

  always_comb begin
    xferValue = '0;
    for (int i = 0; i < int'(NUM_DR); i++) begin
      if (int'(xferSel) == i) xferValue = dataRegs[i*POS_W +: POS_W];
    end
  end

  // Fixed priority: recall, write, transfer, step.
  always_comb begin
    reqCmd = '0;
    if (recallValid) begin
      reqCmd.load  = 1'b1;
      reqCmd.value = recallData;
    end else if (wrValid) begin
      reqCmd.load  = 1'b1;
      reqCmd.value = wrData;
    end else if (xferValid) begin
      reqCmd.load  = 1'b1;
      reqCmd.value = xferValue;
    end else if (stepValid) begin
      reqCmd.stepEn = 1'b1;
      reqCmd.stepUp = stepUp;
    end
  end

  // The datapath register is the last stage of the response delay.
  generate
    if (RESP_DLY <= 1) begin : g_noDelay
      assign cmdOut = reqCmd;
    end else begin : g_delay
      localparam int unsigned STAGES = RESP_DLY - 1;
      wiperCmd_t stage [STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
        end else begin
          stage[0] <= reqCmd;
          for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
        end
      end
      assign cmdOut = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wiper_dpath.sv
module wiper_dpath
  import wiper_pkg::*;
#(
  parameter int unsigned RESET_POS = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  wiperCmd_t        cmdIn,
  output logic [POS_W-1:0] position
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] posNext;

  always_comb begin
    posNext = position;
    if (cmdIn.load) begin
      posNext = cmdIn.value;
    end else if (cmdIn.stepEn) begin
      if (cmdIn.stepUp && position != POS_MAX) posNext = position + 1'b1;
      else if (!cmdIn.stepUp && position != POS_MIN) posNext = position - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) position <= POS_W'(RESET_POS);
    else       position <= posNext;
  end
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder
  import wiper_pkg::*;
#(
  localparam int unsigned TAPS = 1 << POS_W
) (
  input  logic [POS_W-1:0] position,
  output logic [TAPS-1:0]  tapEn
);
  generate
    for (genvar i = 0; i < int'(TAPS); i++) begin : g_tap
      assign tapEn[i] = (position == POS_W'(i));
    end
  endgenerate
endmodule

// File: rtl/wiper_tap_ctrl.sv
module wiper_tap_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned NUM_DR    = 4,
  parameter int unsigned RESP_DLY  = 3,
  parameter int unsigned RESET_POS = 0,
  localparam int unsigned SEL_W    = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
  localparam int unsigned TAPS     = 1 << POS_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    recallValid,
  input  logic [POS_W-1:0]        recallData,
  input  logic                    wrValid,
  input  logic [POS_W-1:0]        wrData,
  input  logic                    xferValid,
  input  logic [SEL_W-1:0]        xferSel,
  input  logic [NUM_DR*POS_W-1:0] dataRegs,
  input  logic                    stepValid,
  input  logic                    stepUp,
  output logic [POS_W-1:0]        position,
  output logic [TAPS-1:0]         tapEn
);
  wiperCmd_t cmdBus;

  wiper_ctrl #(.NUM_DR(NUM_DR), .RESP_DLY(RESP_DLY)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .recallValid(recallValid), .recallData(recallData),
    .wrValid(wrValid), .wrData(wrData),
    .xferValid(xferValid), .xferSel(xferSel), .dataRegs(dataRegs),
    .stepValid(stepValid), .stepUp(stepUp),
    .cmdOut(cmdBus)
  );

  wiper_dpath #(.RESET_POS(RESET_POS)) dpath_i (
    .clk(clk), .rstN(rstN), .cmdIn(cmdBus), .position(position)
  );

  tap_decoder dec_i (.position(position), .tapEn(tapEn));
endmodule

// File: rtl/wiper_tap_chk.sv
module wiper_tap_chk
  import wiper_pkg::*;
#(
  localparam int unsigned TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rstN,
  input wiperCmd_t        cmd,
  input logic [POS_W-1:0] position,
  input logic [TAPS-1:0]  tapEn
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapEn) == 1); // R1
  AST_TAP_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    tapEn[position]); // R1
  AST_LOW_END: assert property (@(posedge clk) disable iff (!rstN)
    position == '0 |-> tapEn[0]); // R2
  AST_HIGH_END: assert property (@(posedge clk) disable iff (!rstN)
    position == POS_MAX |-> tapEn[TAPS-1]); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> position == $past(cmd.value)); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepEn && !cmd.load && cmd.stepUp && position == POS_MAX) |=> position == POS_MAX); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepEn && !cmd.load && !cmd.stepUp && position == '0) |=> position == '0); // R6
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepEn && !cmd.load && cmd.stepUp && position != POS_MAX) |=> position == $past(position) + 1'b1); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.stepEn) |=> $stable(position)); // R9
endmodule

bind wiper_tap_ctrl wiper_tap_chk chk_i (
  .clk(clk), .rstN(rstN), .cmd(cmdBus), .position(position), .tapEn(tapEn)
);

// File: tb/wiper_tap_ctrl_tb_top.sv
module wiper_tap_ctrl_tb_top;
  localparam int DLY = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        recallValid = 0, wrValid = 0, xferValid = 0, stepValid = 0, stepUp = 0;
  logic [5:0]  recallData = '0, wrData = '0;
  logic [1:0]  xferSel = '0;
  logic [23:0] dataRegs;
  logic [5:0]  position;
  logic [63:0] tapEn;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wiper_tap_ctrl #(.NUM_DR(4), .RESP_DLY(DLY), .RESET_POS(0)) dut_i (
    .clk(clk), .rstN(rstN),
    .recallValid(recallValid), .recallData(recallData),
    .wrValid(wrValid), .wrData(wrData),
    .xferValid(xferValid), .xferSel(xferSel), .dataRegs(dataRegs),
    .stepValid(stepValid), .stepUp(stepUp),
    .position(position), .tapEn(tapEn)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [63:0] expTap;
    expTap = 64'd1 << exp;
    checks++;
    if (position !== exp || tapEn !== expTap) begin
      failures++;
      $display("FAIL %s: position=%0d tapEn=%h expected position=%0d tapEn=%h",
               req, position, tapEn, exp, expTap);
    end
  endtask

  task automatic clearReq();
    recallValid = 0; wrValid = 0; xferValid = 0; stepValid = 0;
  endtask

  // Called at a falling edge with the request already set; drops it,
  // verifies the old value one edge early and the new value on time.
  task automatic finish(input string req, input logic [5:0] oldV, input logic [5:0] newV);
    @(negedge clk); clearReq();
    repeat (DLY - 2) @(negedge clk);
    check({req, " early"}, oldV);
    @(negedge clk);
    check(req, newV);
  endtask

  task automatic doWrite(input string req, input logic [5:0] v);
    logic [5:0] oldV;
    oldV = position; wrData = v; wrValid = 1;
    finish(req, oldV, v);
  endtask

  task automatic doStep(input string req, input bit up, input logic [5:0] newV);
    logic [5:0] oldV;
    oldV = position; stepUp = up; stepValid = 1;
    finish(req, oldV, newV);
  endtask

  task automatic t_reset();
    check("R10 reset", 6'd0);
  endtask

  task automatic t_write();
    doWrite("R3 write 0x2A", 6'h2A);
    doWrite("R3 write 0x15", 6'h15);
    repeat (5) @(negedge clk);
    check("R9 idle hold", 6'h15);
  endtask

  task automatic t_xfer();
    logic [5:0] exp;
    for (int i = 0; i < 4; i++) begin
      logic [5:0] oldV;
      oldV = position;
      exp = dataRegs[i*6 +: 6];
      xferSel = 2'(i); xferValid = 1;
      finish("R4 transfer", oldV, exp);
    end
  endtask

  task automatic t_step();
    doWrite("R3 preset", 6'd10);
    doStep("R5 step up", 1'b1, 6'd11);
    doStep("R5 step down", 1'b0, 6'd10);
    // back-to-back steps, one per cycle
    stepUp = 1; stepValid = 1;
    repeat (4) @(negedge clk);
    stepValid = 0;
    repeat (DLY) @(negedge clk);
    check("R5 consecutive steps", 6'd14);
  endtask

  task automatic t_ends();
    doWrite("R2 high end", 6'h3F);
    doStep("R6 saturate high", 1'b1, 6'h3F);
    doWrite("R2 low end", 6'h00);
    doStep("R6 saturate low", 1'b0, 6'h00);
  endtask

  task automatic t_priority();
    logic [5:0] oldV;
    oldV = position;
    recallData = 6'h07; recallValid = 1; wrData = 6'h30; wrValid = 1;
    xferValid = 1; xferSel = 2'd2; stepValid = 1;
    finish("R7 recall wins", oldV, 6'h07);
    oldV = position;
    wrData = 6'h31; wrValid = 1; xferValid = 1; xferSel = 2'd1; stepValid = 1; stepUp = 1;
    finish("R8 write beats transfer", oldV, 6'h31);
    oldV = position;
    xferValid = 1; xferSel = 2'd0; stepValid = 1; stepUp = 1;
    finish("R8 transfer beats step", oldV, dataRegs[5:0]);
    oldV = position;
    recallData = 6'h22; recallValid = 1;
    finish("R7 recall alone", oldV, 6'h22);
  endtask

  initial begin
    dataRegs = {6'h20, 6'h3F, 6'h11, 6'h05};
    @(negedge clk); @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    check("R1 after reset release", 6'd0);
    t_write();
    t_xfer();
    t_step();
    t_ends();
    t_priority();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule